// File: doc/BRIEF.md
# Segment Address Unit with Descriptor Cache

This unit serves one segment register of an address-generation path. It turns an offset into a linear address using that register, in one of two ways. In real mode the 16-bit segment value is multiplied by sixteen and the low 16 bits of the offset are added to it, which gives a 20-bit address. In protected mode the segment value is a selector that points into a descriptor table in memory. The base, limit, granularity and access byte held in the selected descriptor define the segment.

When software writes the register in protected mode, the unit fetches the 8-byte descriptor as two 32-bit reads on a valid/ready memory port. It stores the decoded fields in a hidden cache, and later translations read only that cache. While the fetch runs, `busy` is high and translation requests are stalled. Translation requests come in on a valid/ready channel, and each result leaves one cycle after acceptance on a second valid/ready channel. A result stays on that channel until the consumer takes it, so back-pressure on the result side also stops new requests from being accepted. An offset past the end of the segment produces a result with the fault flag set and the address forced to zero.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset, `busy`, `rsp_valid` and `mem_req_valid` are 0, `seg_value` is 0, `req_ready` is 1. The cached descriptor has base 0, byte-granular limit FFFFh and access byte 93h.
- R2: With `prot_mode`=0, the result address is (segment×16 + offset[15:0]) reduced modulo 2^20 and zero-extended to 32 bits. An offset above FFFFh faults.
- R3: With `prot_mode`=0, a segment write updates `seg_value` and starts no fetch: `busy` and `mem_req_valid` stay 0 and no memory read is issued.
- R4: A segment write with `prot_mode`=1 reads the descriptor from B + index×8. The index is selector[15:3]. B is `ldt_base` when selector[2]=1 and `gdt_base` when it is 0. The first read is at that address and gives the low word, and the second read is at that address +4 and gives the high word. `seg_rpl` shows selector[1:0]. The request address holds steady while `mem_req_valid` waits for `mem_req_ready`.
- R5: The descriptor fields are decoded as follows. Low word: limit[15:0] is bits 15:0 and base[15:0] is bits 31:16. High word: base[23:16] is bits 7:0, the access byte is bits 15:8, limit[19:16] is bits 19:16, the granularity flag is bit 23 and base[31:24] is bits 31:24. `seg_acc` shows the cached access byte. The protected address is base + offset, taken modulo 2^32.
- R6: With granularity 0, an offset above the limit faults, and an offset equal to the limit does not.
- R7: With granularity 1, the end of the segment is limit×4096 + FFFh. An offset above that value faults.
- R8: `busy` rises in the cycle after a protected write is taken and falls after the second read response. `req_ready` is 0 while `busy` is 1.
- R9: A request is taken on `req_valid`&&`req_ready`, and its result is valid in the next cycle. A result that is not accepted stays valid and unchanged until `rsp_ready`.
- R10: A faulting result has `rsp_fault`=1 and `rsp_addr`=0.
- R11: A segment write while `busy` is 1 is ignored: `seg_value` and the fetch in progress are unchanged, and no extra read is issued.
- R12: Once filled, the cache serves every later protected translation with no memory read, and switching `prot_mode` away and back does not disturb it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prot_mode | input | 1 | 1 = protected translation, 0 = real |
| seg_wr | input | 1 | Segment register write strobe |
| seg_wr_data | input | 16 | Value written to the segment register |
| gdt_base | input | 32 | Global descriptor table base address |
| ldt_base | input | 32 | Local descriptor table base address |
| seg_value | output | 16 | Visible segment register value |
| seg_rpl | output | 2 | Requested privilege level of the selector |
| seg_acc | output | 8 | Cached access byte |
| busy | output | 1 | Descriptor fetch in progress |
| mem_req_valid | output | 1 | Descriptor read request valid |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Descriptor read byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Unit accepts read data |
| mem_rsp_data | input | 32 | Read data word |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Translation request accepted |
| req_offset | input | 32 | Offset to translate |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_addr | output | 32 | Linear address (0 on fault) |
| rsp_fault | output | 1 | Limit fault |

## Verification
The bench goes after the edges of the limit check. It tests an offset exactly at the limit and one just past it, for both granularities, and a design that compares with >= or scales the limit without the FFFh fill would flag a good access or pass a bad one. It also tests real-mode wrap past 20 bits and protected wrap past 32 bits, which a design would get wrong by carrying into the upper bits. It checks the fetch addresses for both tables and the order of the two reads, where a swapped table select or word order would decode the wrong base. Last, it checks that a write during a fetch and a mode toggle leave the cache alone, while back-pressure is applied on both handshakes; a design that dropped or repeated a result there would leave the scoreboard out of step.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  localparam int DESC_WORD_W = 32;
  localparam int DESC_LIM_W  = 20;

  typedef struct packed {
    logic [DESC_WORD_W-1:0] base;
    logic [DESC_LIM_W-1:0]  limit;
    logic                   gran;
    logic [7:0]             acc;
  } seg_desc_t;

  typedef enum logic [2:0] {
    FS_IDLE,
    FS_REQ_LO,
    FS_WAIT_LO,
    FS_REQ_HI,
    FS_WAIT_HI
  } fetch_st_e;

  localparam seg_desc_t DESC_RESET = '{
    base:  '0,
    limit: 20'h0FFFF,
    gran:  1'b0,
    acc:   8'h93
  };

  function automatic seg_desc_t unpack_desc(input logic [DESC_WORD_W-1:0] lo,
                                            input logic [DESC_WORD_W-1:0] hi);
    seg_desc_t d;
    d.base  = {hi[31:24], hi[7:0], lo[31:16]};
    d.limit = {hi[19:16], lo[15:0]};
    d.gran  = hi[23];
    d.acc   = hi[15:8];
    return d;
  endfunction

endpackage

// File: rtl/seg_desc_fetch.sv
module seg_desc_fetch
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W  = 16,
  parameter int ADDR_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [SEG_W-1:2]     sel_hi,
  input  logic [ADDR_W-1:0]    gdt_base,
  input  logic [ADDR_W-1:0]    ldt_base,
  output logic                 busy,
  output logic                 mem_req_valid,
  input  logic                 mem_req_ready,
  output logic [ADDR_W-1:0]    mem_req_addr,
  input  logic                 mem_rsp_valid,
  output logic                 mem_rsp_ready,
  input  logic [DESC_WORD_W-1:0] mem_rsp_data,
  output logic                 fill_valid,
  output seg_desc_t            fill_desc
);

  localparam int IDX_SHIFT = 3;
  localparam int WORD_BYTES = DESC_WORD_W / 8;

  fetch_st_e             st_q;
  logic [ADDR_W-1:0]     desc_addr_q;
  logic [DESC_WORD_W-1:0] lo_q;
  logic [ADDR_W-1:0]     tbl_base;
  logic [ADDR_W-1:0]     idx_off;

  assign tbl_base = sel_hi[2] ? ldt_base : gdt_base;
  assign idx_off  = ADDR_W'({sel_hi[SEG_W-1:IDX_SHIFT], {IDX_SHIFT{1'b0}}});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= FS_IDLE;
      desc_addr_q <= '0;
      lo_q        <= '0;
    end else begin
      unique case (st_q)
        FS_IDLE: begin
          if (start) begin
            desc_addr_q <= tbl_base + idx_off;
            st_q        <= FS_REQ_LO;
          end
        end
        FS_REQ_LO:  if (mem_req_ready) st_q <= FS_WAIT_LO;
        FS_WAIT_LO: begin
          if (mem_rsp_valid) begin
            lo_q <= mem_rsp_data;
            st_q <= FS_REQ_HI;
          end
        end
        FS_REQ_HI:  if (mem_req_ready) st_q <= FS_WAIT_HI;
        FS_WAIT_HI: if (mem_rsp_valid) st_q <= FS_IDLE;
        default:    st_q <= FS_IDLE;
      endcase
    end
  end

  always_comb begin
    busy          = (st_q != FS_IDLE);
    mem_req_valid = (st_q == FS_REQ_LO) || (st_q == FS_REQ_HI);
    mem_rsp_ready = (st_q == FS_WAIT_LO) || (st_q == FS_WAIT_HI);
    mem_req_addr  = (st_q == FS_REQ_HI) ? desc_addr_q + ADDR_W'(WORD_BYTES)
                                        : desc_addr_q;
    fill_valid    = (st_q == FS_WAIT_HI) && mem_rsp_valid;
    fill_desc     = unpack_desc(lo_q, mem_rsp_data);
  end

endmodule

// File: rtl/seg_desc_cache.sv
module seg_desc_cache
  import seg_xlate_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      fill_valid,
  input  seg_desc_t fill_desc,
  output seg_desc_t desc
);

  always_ff @(posedge clk) begin
    if (!rst_n)          desc <= DESC_RESET;
    else if (fill_valid) desc <= fill_desc;
  end

endmodule

// File: rtl/seg_addr_calc.sv
module seg_addr_calc
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W       = 16,
  parameter int ADDR_W      = 32,
  parameter int OFF_W       = 32,
  parameter int REAL_ADDR_W = 20,
  parameter int REAL_OFF_W  = 16,
  parameter int PAGE_SHIFT  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prot_mode,
  input  logic [SEG_W-1:0]  seg_q,
  input  seg_desc_t         desc,
  input  logic              busy,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [OFF_W-1:0]  req_offset,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic              rsp_fault
);

  localparam int REAL_SHIFT = REAL_ADDR_W - SEG_W;

  logic [REAL_ADDR_W-1:0] real_sum;
  logic [ADDR_W-1:0]      real_lin;
  logic                   real_fault;
  logic [OFF_W-1:0]       eff_lim;
  logic [ADDR_W-1:0]      prot_lin;
  logic                   prot_fault;
  logic [ADDR_W-1:0]      lin_n;
  logic                   fault_n;
  logic                   take;

  assign real_sum   = {seg_q, {REAL_SHIFT{1'b0}}}
                    + REAL_ADDR_W'(req_offset[REAL_OFF_W-1:0]);
  assign real_fault = |req_offset[OFF_W-1:REAL_OFF_W];

  generate
    if (REAL_ADDR_W < ADDR_W) begin : g_real_pad
      assign real_lin = {{(ADDR_W-REAL_ADDR_W){1'b0}}, real_sum};
    end else begin : g_real_full
      assign real_lin = real_sum[ADDR_W-1:0];
    end
  endgenerate

  assign eff_lim    = desc.gran ? OFF_W'({desc.limit, {PAGE_SHIFT{1'b1}}})
                                : OFF_W'(desc.limit);
  assign prot_fault = req_offset > eff_lim;
  assign prot_lin   = desc.base + ADDR_W'(req_offset);

  assign fault_n   = prot_mode ? prot_fault : real_fault;
  assign lin_n     = prot_mode ? prot_lin   : real_lin;
  assign req_ready = !busy && (!rsp_valid || rsp_ready);
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
      rsp_fault <= 1'b0;
    end else if (take) begin
      rsp_valid <= 1'b1;
      rsp_addr  <= fault_n ? '0 : lin_n;
      rsp_fault <= fault_n;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W       = 16,
  parameter int ADDR_W      = 32,
  parameter int OFF_W       = 32,
  parameter int REAL_ADDR_W = 20,
  parameter int REAL_OFF_W  = 16,
  parameter int PAGE_SHIFT  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prot_mode,
  input  logic              seg_wr,
  input  logic [SEG_W-1:0]  seg_wr_data,
  input  logic [ADDR_W-1:0] gdt_base,
  input  logic [ADDR_W-1:0] ldt_base,
  output logic [SEG_W-1:0]  seg_value,
  output logic [1:0]        seg_rpl,
  output logic [7:0]        seg_acc,
  output logic              busy,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [31:0]       mem_rsp_data,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [OFF_W-1:0]  req_offset,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic              rsp_fault
);

  logic      wr_take;
  logic      fetch_start;
  logic      fill_valid;
  seg_desc_t fill_desc;
  seg_desc_t cur_desc;

  assign wr_take     = seg_wr && !busy;
  assign fetch_start = wr_take && prot_mode;

  always_ff @(posedge clk) begin
    if (!rst_n)       seg_value <= '0;
    else if (wr_take) seg_value <= seg_wr_data;
  end

  assign seg_rpl = seg_value[1:0];
  assign seg_acc = cur_desc.acc;

  seg_desc_fetch #(
    .SEG_W (SEG_W),
    .ADDR_W(ADDR_W)
  ) u_fetch (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (fetch_start),
    .sel_hi       (seg_wr_data[SEG_W-1:2]),
    .gdt_base     (gdt_base),
    .ldt_base     (ldt_base),
    .busy         (busy),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_addr (mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_ready(mem_rsp_ready),
    .mem_rsp_data (mem_rsp_data),
    .fill_valid   (fill_valid),
    .fill_desc    (fill_desc)
  );

  seg_desc_cache u_cache (
    .clk       (clk),
    .rst_n     (rst_n),
    .fill_valid(fill_valid),
    .fill_desc (fill_desc),
    .desc      (cur_desc)
  );

  seg_addr_calc #(
    .SEG_W      (SEG_W),
    .ADDR_W     (ADDR_W),
    .OFF_W      (OFF_W),
    .REAL_ADDR_W(REAL_ADDR_W),
    .REAL_OFF_W (REAL_OFF_W),
    .PAGE_SHIFT (PAGE_SHIFT)
  ) u_calc (
    .clk       (clk),
    .rst_n     (rst_n),
    .prot_mode (prot_mode),
    .seg_q     (seg_value),
    .desc      (cur_desc),
    .busy      (busy),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_offset(req_offset),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_addr  (rsp_addr),
    .rsp_fault (rsp_fault)
  );

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        prot_mode,
  input logic        seg_wr,
  input logic [15:0] seg_wr_data,
  input logic [15:0] seg_value,
  input logic        busy,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [31:0] mem_req_addr,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_addr,
  input logic        rsp_fault
);

  AST_REAL_WR_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!prot_mode && seg_wr && !busy) |=> (!busy && !mem_req_valid)); // R3

  AST_MEMREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R4

  AST_PROT_WR_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_mode && seg_wr && !busy) |=> (busy && seg_value == $past(seg_wr_data))); // R8

  AST_BUSY_STALLS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready); // R8

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) && $stable(rsp_fault))); // R9

  AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_addr == 32'h0)); // R10

  AST_BUSY_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && seg_wr) |=> $stable(seg_value)); // R11

endmodule

bind seg_xlate_unit seg_xlate_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .prot_mode    (prot_mode),
  .seg_wr       (seg_wr),
  .seg_wr_data  (seg_wr_data),
  .seg_value    (seg_value),
  .busy         (busy),
  .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready),
  .mem_req_addr (mem_req_addr),
  .req_ready    (req_ready),
  .rsp_valid    (rsp_valid),
  .rsp_ready    (rsp_ready),
  .rsp_addr     (rsp_addr),
  .rsp_fault    (rsp_fault)
);

// File: tb/sim_seg_xlate_unit.sv
`timescale 1ns/1ps
module sim_seg_xlate_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prot_mode = 1'b1;
  logic        seg_wr = 1'b0;
  logic [15:0] seg_wr_data = '0;
  logic [31:0] gdt_base = 32'h0000_1000;
  logic [31:0] ldt_base = 32'h0000_8000;
  logic [15:0] seg_value;
  logic [1:0]  seg_rpl;
  logic [7:0]  seg_acc;
  logic        busy;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic        mem_rsp_ready;
  logic [31:0] mem_rsp_data = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_offset = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_addr;
  logic        rsp_fault;

  always #4 clk = ~clk;

  seg_xlate_unit u0 (.*);

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] q_addr[$];
  logic        q_fault[$];
  string       q_tag[$];
  logic [31:0] addr_log[$];
  int          read_count = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    case (a)
      32'h0000_1010: return 32'h0000_00FF;
      32'h0000_1014: return 32'h0000_9210;
      32'h0000_8028: return 32'h0000_0010;
      32'h0000_802C: return 32'h0080_9228;
      32'h0000_1008: return 32'hF000_FFFF;
      32'h0000_100C: return 32'hFF8F_9AFF;
      default:       return 32'hDEAD_BEEF;
    endcase
  endfunction

  // memory model with request stalls and response latency
  initial begin
    bit          took, fin, have;
    logic [31:0] ta, pa;
    int          lat;
    have = 0; lat = 0; pa = '0;
    forever begin
      @(negedge clk);
      took = mem_req_valid && mem_req_ready;
      ta   = mem_req_addr;
      fin  = mem_rsp_valid && mem_rsp_ready;
      @(posedge clk); #1;
      if (fin) mem_rsp_valid = 1'b0;
      if (took) begin
        addr_log.push_back(ta);
        read_count++;
        pa = ta; have = 1; lat = 2;
        mem_req_ready = 1'b0;
      end else if (have) begin
        if (lat == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = mem_word(pa);
          have = 0;
        end else lat--;
      end else if (!mem_rsp_valid) begin
        mem_req_ready = !mem_req_ready;
      end
    end
  end

  // result back-pressure
  initial begin
    logic [7:0] lfsr;
    lfsr = 8'hA5;
    forever begin
      @(posedge clk); #1;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      rsp_ready = lfsr[0] | lfsr[1];
    end
  end

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rsp_valid && rsp_ready) begin
        if (q_addr.size() == 0) begin
          chk(0, "R9 unexpected result", rsp_addr, 32'h0);
        end else begin
          logic [31:0] ea;
          logic        ef;
          string       tg;
          ea = q_addr.pop_front();
          ef = q_fault.pop_front();
          tg = q_tag.pop_front();
          chk(rsp_addr == ea, {tg, " addr"}, rsp_addr, ea);
          chk(rsp_fault == ef, {tg, " fault"}, {31'b0, rsp_fault}, {31'b0, ef});
        end
      end
    end
  end

  task automatic issue(input logic [31:0] off, input logic [31:0] ea,
                       input logic ef, input string tag);
    bit acc;
    q_addr.push_back(ea);
    q_fault.push_back(ef);
    q_tag.push_back(tag);
    req_offset = off;
    req_valid  = 1'b1;
    do begin
      @(negedge clk);
      acc = req_ready;
      @(posedge clk); #1;
    end while (!acc);
    req_valid = 1'b0;
  endtask

  task automatic seg_write(input logic [15:0] v);
    seg_wr_data = v;
    seg_wr      = 1'b1;
    @(posedge clk); #1;
    seg_wr      = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
    @(posedge clk); #1;
  endtask

  task automatic drain();
    for (int i = 0; i < 200; i++) begin
      if (q_addr.size() == 0) break;
      @(posedge clk); #1;
    end
    chk(q_addr.size() == 0, "R9 results outstanding", q_addr.size(), 0);
  endtask

  initial begin
    #1600000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int rc, lb;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!busy, "R1 busy", busy, 0);
    chk(!rsp_valid, "R1 rsp_valid", rsp_valid, 0);
    chk(!mem_req_valid, "R1 mem_req_valid", mem_req_valid, 0);
    chk(seg_value == 16'h0, "R1 seg_value", seg_value, 0);
    chk(req_ready, "R1 req_ready", req_ready, 1);
    chk(seg_acc == 8'h93, "R1 seg_acc", seg_acc, 32'h93);
    @(posedge clk); #1;
    issue(32'h0000_FFFF, 32'h0000_FFFF, 0, "R1 reset limit");
    issue(32'h0001_0000, 32'h0, 1, "R1 R10 reset past limit");

    // real mode
    prot_mode = 1'b0;
    rc = read_count;
    seg_write(16'h3034);
    @(negedge clk);
    chk(!busy && !mem_req_valid, "R3 no fetch", {busy, mem_req_valid}, 0);
    chk(seg_value == 16'h3034, "R3 seg_value", seg_value, 32'h3034);
    @(posedge clk); #1;
    issue(32'h0000_1234, 32'h0003_1574, 0, "R2 real 3034:1234");
    seg_write(16'h3456);
    issue(32'h0000_ABCD, 32'h0003_F12D, 0, "R2 real 3456:ABCD");
    seg_write(16'hFFFF);
    issue(32'h0000_FFFF, 32'h0000_FFEF, 0, "R2 real wrap");
    issue(32'h0001_0000, 32'h0, 1, "R2 R10 real offset fault");
    drain();
    chk(read_count == rc, "R3 no reads", read_count, rc);

    // protected, global table, byte granularity
    prot_mode = 1'b1;
    lb = addr_log.size();
    seg_write(16'h0010);
    @(negedge clk);
    chk(busy && !req_ready, "R8 busy stalls", {busy, req_ready}, 2);
    @(posedge clk); #1;
    issue(32'h0000_0000, 32'h0010_0000, 0, "R8 R6 stalled request");
    wait_idle();
    chk(addr_log.size() == lb + 2, "R4 read count", addr_log.size() - lb, 2);
    if (addr_log.size() >= lb + 2) begin
      chk(addr_log[lb] == 32'h0000_1010, "R4 low addr", addr_log[lb], 32'h1010);
      chk(addr_log[lb+1] == 32'h0000_1014, "R4 high addr", addr_log[lb+1], 32'h1014);
    end
    chk(seg_acc == 8'h92, "R5 access byte", seg_acc, 32'h92);
    chk(seg_rpl == 2'd0, "R4 rpl", seg_rpl, 0);
    issue(32'h0000_00FF, 32'h0010_00FF, 0, "R6 at limit");
    issue(32'h0000_0100, 32'h0, 1, "R6 R10 past limit");

    // protected, local table, page granularity, write during fetch
    lb = addr_log.size();
    seg_write(16'h002F);
    @(negedge clk);
    chk(busy, "R8 busy rises", busy, 1);
    @(posedge clk); #1;
    seg_write(16'h0008);
    wait_idle();
    chk(seg_value == 16'h002F, "R11 write ignored", seg_value, 32'h2F);
    chk(addr_log.size() == lb + 2, "R11 no extra read", addr_log.size() - lb, 2);
    if (addr_log.size() >= lb + 2) begin
      chk(addr_log[lb] == 32'h0000_8028, "R4 local low", addr_log[lb], 32'h8028);
      chk(addr_log[lb+1] == 32'h0000_802C, "R4 local high", addr_log[lb+1], 32'h802C);
    end
    chk(seg_rpl == 2'd3, "R4 rpl", seg_rpl, 3);
    issue(32'h0001_0FFF, 32'h0029_0FFF, 0, "R7 page end");
    issue(32'h0001_1000, 32'h0, 1, "R7 R10 past page end");
    issue(32'h0000_0005, 32'h0028_0005, 0, "R7 inside");

    // cache retained across mode toggle
    drain();
    rc = read_count;
    prot_mode = 1'b0;
    issue(32'h0000_0010, 32'h0000_0300, 0, "R12 real with selector value");
    prot_mode = 1'b1;
    issue(32'h0001_0FFF, 32'h0029_0FFF, 0, "R12 cache kept");
    drain();
    chk(read_count == rc, "R12 no reads", read_count, rc);

    // wrap of 32-bit base + offset
    seg_write(16'h0008);
    wait_idle();
    chk(seg_acc == 8'h9A, "R5 access byte", seg_acc, 32'h9A);
    issue(32'h0000_2000, 32'h0000_1000, 0, "R5 base wrap");
    issue(32'hFFFF_FFFF, 32'hFFFF_EFFF, 0, "R7 full span");
    drain();

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule